// File: doc/BRIEF.md
# Givens Rotation QR Triangular Array

This block brings a real-valued 8x8 channel matrix, already column-ordered, to upper-triangular form by Givens rotations. A 4x4 complex channel enters in its real 8x8 form, one row per handshake. The rows pass down a triangular grid of cells. Each diagonal (boundary) cell keeps one diagonal entry of R. It turns that entry and the incoming element into a cosine/sine pair. The internal cells of the same grid row then apply that pair to the rest of the row. The rotated remainder moves down to the next grid row.

A `start` pulse empties every cell before a new matrix. Eight rows are then accepted. When the last row has left the bottom cell, `done` rises. R can then be read at any time through a combinational row/column address. Square root and division run on sequential bit-search units. The array therefore accepts one row, works it through all eight grid rows one stage at a time, and holds `in_ready` low until that row is finished.

Samples are signed 18-bit two's complement with 14 fraction bits, so 16384 stands for 1.0. All rules below are stated on these integer codes.

Top module: `qr_givens_array`

## Requirements
- R1: After reset, and in the cycle after a `start` pulse, `done` is 0, `in_ready` is 1, and every R entry reads 0.
- R2: A row is taken on a rising clock edge where `in_valid` and `in_ready` are both 1. Element j of the row sits in `in_row[18j+17:18j]`. From the next cycle, `in_ready` stays 0 until that row has passed every grid row.
- R3: A diagonal cell holding R that receives X stores R' = min(131071, floor(sqrt(R*R + X*X))).
- R4: For each X, the rotation is c = min(16384, floor(R*16384/R')) and s = sgn(X)*min(16384, floor(|X|*16384/R')). When R' = 0 it is c = 16384, s = 0.
- R5: An internal cell holding r that receives x and (c, s) stores sat(floor((c*r + s*x)/16384)). It passes sat(floor((c*x - s*r)/16384)) downward. The division rounds toward minus infinity, and sat clamps to [-131072, 131071].
- R6: Grid row k uses only the rotation made by diagonal cell k. The value that internal cell (k, j) passes down becomes the input of column j in grid row k+1. Every input row visits all eight grid rows in order 0 to 7.
- R7: When the eighth row has finished, `done` goes to 1. It stays 1 until `start`. While `done` is 1, `in_ready` is 0, so further rows change no R entry.
- R8: `rd_data` equals R[`rd_row`][`rd_col`] in the same cycle. Entries below the diagonal (`rd_col` < `rd_row`) read 0.
- R9: `start` has priority. A row offered in the same cycle as `start` is dropped. A `start` while a row is in flight abandons that row and clears all cells.
- R10: A matrix of all zeros leaves every R entry at 0, because each rotation then falls back to c = 16384, s = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears all cells and begins a new matrix |
| in_valid | input | 1 | Row offered on `in_row` |
| in_ready | output | 1 | Array can take a row |
| in_row | input | 144 | Eight signed 18-bit elements, element j at bits 18j+17:18j |
| done | output | 1 | All eight rows processed; R is final |
| rd_row | input | 3 | Readout row address |
| rd_col | input | 3 | Readout column address |
| rd_data | output | 18 | R entry at the addressed position |

## Verification
Two events can fall in the same cycle: a `start` pulse and a row handshake. A `start` can also arrive while a rotation is still working inside a diagonal cell. The bench raises `start` and `in_valid` together with a junk row. It then feeds a clean matrix without a further `start`. Every R entry must match a model that never saw the junk row. For the mid-row case, a `start` lands a few cycles after the fourth row is taken. R must read all zero right after that, and the next matrix must come out exact.

// File: rtl/qr_pkg.sv
`timescale 1ns/1ps
package qr_pkg;
  localparam int DW   = 18;
  localparam int FW   = 14;
  localparam int NDEF = 8;
  localparam int AW   = 2*DW + 2;

  typedef logic signed [DW-1:0] smp_t;

  localparam smp_t SMP_ONE = smp_t'(1 << FW);
  localparam smp_t SMP_MAX = smp_t'((1 << (DW-1)) - 1);
  localparam smp_t SMP_MIN = smp_t'(-(1 << (DW-1)));

  // Clamp a wide signed value into the sample range.
  function automatic smp_t sat_acc(input logic signed [AW-1:0] v);
    if (v > AW'(SMP_MAX)) return SMP_MAX;
    else if (v < AW'(SMP_MIN)) return SMP_MIN;
    else return v[DW-1:0];
  endfunction

  // Rotation step: sat(floor((c*a + s*b) / 2^FW)).
  function automatic smp_t rot_apply(input smp_t a, input smp_t b,
                                     input smp_t c, input smp_t s);
    logic signed [AW-1:0] acc;
    acc = AW'(c) * AW'(a) + AW'(s) * AW'(b);
    return sat_acc(acc >>> FW);
  endfunction
endpackage

// File: rtl/qr_bitfind.sv
`timescale 1ns/1ps
// Sequential bit search: finds the largest q with prod(q) <= op.
// SQRT_MODE picks prod(q) = q*q, otherwise prod(q) = q*den.
module qr_bitfind #(
  parameter int QW        = 18,
  parameter int OPW       = 36,
  parameter int DENW      = 18,
  parameter bit SQRT_MODE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            go,
  input  logic [OPW-1:0]  op,
  input  logic [DENW-1:0] den,
  output logic [QW-1:0]   q,
  output logic            done
);
  localparam int MW = (QW + 1 > DENW) ? QW + 1 : DENW;
  localparam int PW = QW + 1 + MW;
  localparam int BW = $clog2(QW);

  logic [OPW-1:0]  op_l;
  logic [DENW-1:0] den_l;
  logic [BW-1:0]   bitp;
  logic            run;
  logic [QW-1:0]   trial;
  logic [QW:0]     q_up;
  logic [PW-1:0]   p_trial, p_q, p_q1;
  logic            fits;

  assign trial = q | (QW'(1) << bitp);
  assign q_up  = {1'b0, q} + (QW+1)'(1);

  generate
    if (SQRT_MODE) begin : g_square
      logic unused_den;
      assign unused_den = ^den_l;
      assign p_trial = PW'(trial) * PW'(trial);
      assign p_q     = PW'(q) * PW'(q);
      assign p_q1    = PW'(q_up) * PW'(q_up);
    end else begin : g_divide
      assign p_trial = PW'(trial) * PW'(den_l);
      assign p_q     = PW'(q) * PW'(den_l);
      assign p_q1    = PW'(q_up) * PW'(den_l);
    end
  endgenerate

  assign fits = (p_trial <= PW'(op_l));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_l  <= '0;
      den_l <= '0;
      q     <= '0;
      bitp  <= '0;
      run   <= 1'b0;
      done  <= 1'b0;
    end else if (clr) begin
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        op_l  <= op;
        den_l <= den;
        q     <= '0;
        bitp  <= BW'(QW - 1);
        run   <= 1'b1;
      end else if (run) begin
        if (fits) q <= trial;
        if (bitp == '0) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          bitp <= bitp - BW'(1);
        end
      end
    end
  end

  // R3 (root) and R4 (quotient): result is the floor, neither too small nor too large
  assert_floor_search_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((p_q <= PW'(op_l)) && ((&q) || (p_q1 > PW'(op_l)))));
endmodule

// File: rtl/qr_bound_cell.sv
`timescale 1ns/1ps
// Diagonal cell: keeps one diagonal entry and makes the rotation pair.
module qr_bound_cell
  import qr_pkg::*;
#(
  parameter int FRAC = FW
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic kick,
  input  smp_t x,
  output smp_t r,
  output smp_t c,
  output smp_t s,
  output logic vld
);
  localparam int OPW  = 2*DW;
  localparam int QDW  = FRAC + 1;
  localparam int NUMW = DW + FRAC;

  typedef enum logic [1:0] {D_IDLE, D_SQ, D_DV} dst_t;
  dst_t st;

  smp_t            xl, rp_l, rp_sat;
  logic            sq_go, dv_go, sq_done, dc_done, ds_done;
  logic [DW-1:0]   root, xmag, rmag;
  logic [OPW-1:0]  sum_op;
  logic [NUMW-1:0] num_c, num_s;
  logic [QDW-1:0]  qc, qs;

  function automatic smp_t clamp_one(input logic [QDW-1:0] v);
    return (v > QDW'(SMP_ONE)) ? SMP_ONE : smp_t'(v);
  endfunction

  assign rmag   = r;
  assign xmag   = xl[DW-1] ? DW'(-xl) : DW'(xl);
  assign sum_op = OPW'(rmag) * OPW'(rmag) + OPW'(xmag) * OPW'(xmag);
  assign rp_sat = (root > DW'(SMP_MAX)) ? SMP_MAX : smp_t'(root);
  assign num_c  = NUMW'(rmag) << FRAC;
  assign num_s  = NUMW'(xmag) << FRAC;

  qr_bitfind #(.QW(DW), .OPW(OPW), .DENW(DW), .SQRT_MODE(1'b1)) u_root (
    .clk(clk), .rst_n(rst_n), .clr(clr), .go(sq_go),
    .op(sum_op), .den('0), .q(root), .done(sq_done));

  qr_bitfind #(.QW(QDW), .OPW(NUMW), .DENW(DW), .SQRT_MODE(1'b0)) u_div_c (
    .clk(clk), .rst_n(rst_n), .clr(clr), .go(dv_go),
    .op(num_c), .den(rp_l), .q(qc), .done(dc_done));

  qr_bitfind #(.QW(QDW), .OPW(NUMW), .DENW(DW), .SQRT_MODE(1'b0)) u_div_s (
    .clk(clk), .rst_n(rst_n), .clr(clr), .go(dv_go),
    .op(num_s), .den(rp_l), .q(qs), .done(ds_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= D_IDLE; r <= '0; c <= SMP_ONE; s <= '0; vld <= 1'b0;
      xl <= '0; rp_l <= '0; sq_go <= 1'b0; dv_go <= 1'b0;
    end else if (clr) begin
      st <= D_IDLE; r <= '0; c <= SMP_ONE; s <= '0; vld <= 1'b0;
      xl <= '0; rp_l <= '0; sq_go <= 1'b0; dv_go <= 1'b0;
    end else begin
      vld   <= 1'b0;
      sq_go <= 1'b0;
      dv_go <= 1'b0;
      case (st)
        D_IDLE: if (kick) begin
          xl    <= x;
          sq_go <= 1'b1;
          st    <= D_SQ;
        end
        D_SQ: if (sq_done) begin
          if (rp_sat == '0) begin
            r   <= '0;
            c   <= SMP_ONE;
            s   <= '0;
            vld <= 1'b1;
            st  <= D_IDLE;
          end else begin
            rp_l  <= rp_sat;
            dv_go <= 1'b1;
            st    <= D_DV;
          end
        end
        D_DV: if (dc_done && ds_done) begin
          r   <= rp_l;
          c   <= clamp_one(qc);
          s   <= xl[DW-1] ? -clamp_one(qs) : clamp_one(qs);
          vld <= 1'b1;
          st  <= D_IDLE;
        end
        default: st <= D_IDLE;
      endcase
    end
  end

  assert_diag_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !r[DW-1]);
  assert_rot_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (!c[DW-1] && c <= SMP_ONE && s <= SMP_ONE && s >= -SMP_ONE));
  assert_degenerate_rot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && r == '0) |-> (c == SMP_ONE && s == '0));
  assert_kick_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> (st == D_IDLE));
endmodule

// File: rtl/qr_inner_cell.sv
`timescale 1ns/1ps
// Internal cell: applies the row's rotation to its stored entry.
module qr_inner_cell
  import qr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  smp_t x,
  input  smp_t c,
  input  smp_t s,
  output smp_t r,
  output smp_t xo
);
  assign xo = rot_apply(x, r, c, smp_t'(-s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   r <= '0;
    else if (clr) r <= '0;
    else if (en)  r <= rot_apply(r, x, c, s);
  end

  assert_inner_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(r));
endmodule

// File: rtl/qr_givens_array.sv
`timescale 1ns/1ps
module qr_givens_array
  import qr_pkg::*;
#(
  parameter int N = NDEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [N*DW-1:0]        in_row,
  output logic                   done,
  input  logic [$clog2(N)-1:0]   rd_row,
  input  logic [$clog2(N)-1:0]   rd_col,
  output smp_t                   rd_data
);
  localparam int SW  = $clog2(N);
  localparam int RCW = $clog2(N + 1);

  typedef enum logic {A_IDLE, A_RUN} ast_t;
  ast_t st;

  smp_t           vec [N];
  logic [SW-1:0]  stg;
  logic [RCW-1:0] rows;
  logic           kick, done_q;

  logic [N-1:0]   rot_vld;
  smp_t           c_w [N];
  smp_t           s_w [N];
  smp_t           rdiag [N];
  smp_t           r_in [N][N];
  smp_t           xo [N][N];

  // Named events for the assertions
  logic busy, accept, stage_fin, row_fin;
  assign busy      = (st == A_RUN);
  assign in_ready  = (st == A_IDLE) && !done_q;
  assign accept    = in_valid && in_ready && !start;
  assign stage_fin = busy && rot_vld[stg];
  assign row_fin   = stage_fin && (stg == SW'(N - 1));
  assign done      = done_q;

  genvar gi, gj;
  generate
    for (gi = 0; gi < N; gi++) begin : g_row
      qr_bound_cell u_diag (
        .clk(clk), .rst_n(rst_n), .clr(start),
        .kick(kick && (stg == SW'(gi))), .x(vec[gi]),
        .r(rdiag[gi]), .c(c_w[gi]), .s(s_w[gi]), .vld(rot_vld[gi]));
      for (gj = 0; gj < N; gj++) begin : g_col
        if (gj > gi) begin : g_cell
          qr_inner_cell u_in (
            .clk(clk), .rst_n(rst_n), .clr(start), .en(rot_vld[gi]),
            .x(vec[gj]), .c(c_w[gi]), .s(s_w[gi]),
            .r(r_in[gi][gj]), .xo(xo[gi][gj]));
        end else begin : g_tie
          assign r_in[gi][gj] = '0;
          assign xo[gi][gj]   = '0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= A_IDLE; stg <= '0; rows <= '0; kick <= 1'b0; done_q <= 1'b0;
      for (int j = 0; j < N; j++) vec[j] <= '0;
    end else if (start) begin
      st <= A_IDLE; stg <= '0; rows <= '0; kick <= 1'b0; done_q <= 1'b0;
    end else begin
      kick <= 1'b0;
      case (st)
        A_IDLE: if (accept) begin
          for (int j = 0; j < N; j++) vec[j] <= in_row[j*DW +: DW];
          stg  <= '0;
          kick <= 1'b1;
          st   <= A_RUN;
        end
        A_RUN: if (stage_fin) begin
          for (int j = 0; j < N; j++)
            if (SW'(j) > stg) vec[j] <= xo[stg][j];
          if (row_fin) begin
            st   <= A_IDLE;
            rows <= rows + RCW'(1);
            if (rows == RCW'(N - 1)) done_q <= 1'b1;
          end else begin
            stg  <= stg + SW'(1);
            kick <= 1'b1;
          end
        end
        default: st <= A_IDLE;
      endcase
    end
  end

  always_comb begin
    if (rd_col == rd_row)     rd_data = rdiag[rd_row];
    else if (rd_col > rd_row) rd_data = r_in[rd_row][rd_col];
    else                      rd_data = '0;
  end

  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && in_ready));
  assert_accept_starts_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !in_ready));
  assert_single_rotation_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rot_vld));
  assert_rotation_in_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|rot_vld) |-> (busy && rot_vld[stg]));
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: tb/qr_givens_array_tb_top.sv
`timescale 1ns/1ps
module qr_givens_array_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int DW = 18;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [N*DW-1:0] in_row = '0;
  logic in_ready, done;
  logic [2:0] rd_row = '0, rd_col = '0;
  logic signed [DW-1:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  qr_givens_array dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(in_ready), .in_row(in_row), .done(done),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data));

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;
  longint a_m [N][N];
  longint e_r [N][N];
  longint exp_q [$];
  string  tag_q [$];
  int     pos_q [$];
  int unsigned seed = 32'h1234_5678;

  task automatic check(input string tag, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---- reference model, restated from the requirements ----
  function automatic longint int_sqrt(input longint v);
    longint lo = 0, hi = longint'(1) << 19, mid;
    while (lo < hi) begin
      mid = (lo + hi + 1) / 2;
      if (mid * mid <= v) lo = mid; else hi = mid - 1;
    end
    return lo;
  endfunction

  function automatic longint floor_q14(input longint v);
    longint q = v / 16384;
    if ((v % 16384 != 0) && (v < 0)) q = q - 1;
    return q;
  endfunction

  function automatic longint clip(input longint v);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return v;
  endfunction

  function automatic longint min_one(input longint v);
    return (v > 16384) ? 16384 : v;
  endfunction

  task automatic compute_model();
    longint x [N];
    longint rv, rp, c, s, ro, mag;
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) e_r[i][j] = 0;
    for (int row = 0; row < N; row++) begin
      for (int j = 0; j < N; j++) x[j] = a_m[row][j];
      for (int k = 0; k < N; k++) begin
        rv = e_r[k][k];
        rp = int_sqrt(rv * rv + x[k] * x[k]);
        if (rp > 131071) rp = 131071;
        if (rp == 0) begin
          c = 16384; s = 0;
        end else begin
          c = min_one((rv * 16384) / rp);
          mag = (x[k] < 0) ? -x[k] : x[k];
          s = min_one((mag * 16384) / rp);
          if (x[k] < 0) s = -s;
        end
        e_r[k][k] = rp;
        for (int j = k + 1; j < N; j++) begin
          ro = e_r[k][j];
          e_r[k][j] = clip(floor_q14(c * ro + s * x[j]));
          x[j]      = clip(floor_q14(c * x[j] - s * ro));
        end
      end
    end
  endtask

  task automatic push_expected();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        exp_q.push_back(e_r[r][c]);
        pos_q.push_back(r * N + c);
        if (c == r)      tag_q.push_back("R3 R4 diagonal");
        else if (c > r)  tag_q.push_back("R5 R6 upper");
        else             tag_q.push_back("R8 below diagonal");
      end
  endtask

  // ---- monitor: pops expected R entries once the array reports done ----
  initial begin
    int p;
    forever begin
      @(negedge clk);
      if (done && exp_q.size() > 0) begin
        while (exp_q.size() > 0) begin
          p = pos_q.pop_front();
          rd_row = 3'(p / N);
          rd_col = 3'(p % N);
          #1;
          check(tag_q.pop_front(), longint'(rd_data), exp_q.pop_front());
          @(negedge clk);
        end
      end
    end
  end

  // ---- driver ----
  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_row(input int r);
    @(negedge clk);
    in_valid = 1'b1;
    for (int j = 0; j < N; j++) in_row[j*DW +: DW] = DW'(a_m[r][j]);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 ready low while row in flight", longint'(in_ready), 0);
  endtask

  task automatic run_matrix(input bit do_start);
    if (do_start) pulse_start();
    compute_model();
    push_expected();
    for (int r = 0; r < N; r++) send_row(r);
    while (!done) @(negedge clk);
    check("R7 input closed when done", longint'(in_ready), 0);
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_cleared(input string tag);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        @(negedge clk);
        rd_row = 3'(r); rd_col = 3'(c);
        #1;
        check(tag, longint'(rd_data), 0);
      end
  endtask

  function automatic longint next_val(input int span);
    seed = seed * 32'd1103515245 + 32'd12345;
    return longint'((seed >> 8) % (2 * span + 1)) - span;
  endfunction

  task automatic fill_random(input int span);
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) a_m[i][j] = next_val(span);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done low after reset", longint'(done), 0);
    check("R1 ready high after reset", longint'(in_ready), 1);
    check_cleared("R1 R8 cleared after reset");

    // identity at 1.0
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) a_m[i][j] = (i == j) ? 16384 : 0;
    run_matrix(1'b1);

    // small random values
    fill_random(8192);
    run_matrix(1'b1);

    // R7: rows offered while done change nothing
    @(negedge clk);
    in_valid = 1'b1;
    for (int j = 0; j < N; j++) in_row[j*DW +: DW] = DW'(20000 + j);
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    check("R7 done still high", longint'(done), 1);
    rd_row = 3'd0; rd_col = 3'd0; #1;
    check("R7 R[0][0] unchanged", longint'(rd_data), e_r[0][0]);
    rd_row = 3'd2; rd_col = 3'd5; #1;
    check("R7 R[2][5] unchanged", longint'(rd_data), e_r[2][5]);

    // R10: all-zero matrix
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) a_m[i][j] = 0;
    run_matrix(1'b1);
    rd_row = 3'd3; rd_col = 3'd6; #1;
    check("R10 zero matrix entry", longint'(rd_data), 0);

    // R9: start and a row handshake in the same cycle
    @(negedge clk);
    start = 1'b1; in_valid = 1'b1;
    for (int j = 0; j < N; j++) in_row[j*DW +: DW] = DW'(30000 - j);
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    check("R9 colliding row dropped, ready", longint'(in_ready), 1);
    check("R1 done cleared by start", longint'(done), 0);
    fill_random(6000);
    run_matrix(1'b0);

    // R9: start while a row is in flight
    pulse_start();
    fill_random(8192);
    for (int r = 0; r < 4; r++) send_row(r);
    repeat (10) @(negedge clk);
    pulse_start();
    check("R1 ready after abort", longint'(in_ready), 1);
    check_cleared("R9 abort clears cells");
    fill_random(4000);
    run_matrix(1'b1);

    // large values, exercising saturation
    fill_random(131071);
    run_matrix(1'b1);

    // negative leading column
    fill_random(8192);
    for (int i = 0; i < N; i++) a_m[i][0] = -16000 + i * 100;
    run_matrix(1'b1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule